// File: doc/BRIEF.md
# Dual-PC Message Handler Fetch Switch

This block is the fetch-address control of a small processor that keeps two program counters: one for the ongoing computation and one for a short message handler. All other processor state is shared by the two threads. While no message is being served, fetch runs from the computation counter. When a message reaches the node, the block takes the handler entry address carried at the head of that message, loads it into the handler counter and moves fetch onto it on the next instruction boundary. The handler ends with a swap instruction, and fetch goes back to the computation counter with no bubble and no flush.

A message is accepted only on an instruction boundary. If its target process is not the one now running, no switch takes place. The message is consumed and a one-cycle kernel interrupt request is raised instead. The arrival side is a valid/ready stream. The sender holds `msg_valid` and the message fields steady until it sees `msg_ready`. `msg_ready` is high only on a fetch boundary while the computation counter is selected. A handler therefore always runs to completion before the next message is taken. Fetch, branch and swap inputs come from the decode stage as plain control pins.

Top module: `msg_fetch_switch`

## Requirements
- R1: After reset, `fetch_addr` equals the RESET_PC parameter, `in_handler` is 0 and `kern_irq` is 0.
- R2: On a cycle with `fetch_adv`=1 and `br_taken`=0, the selected counter advances by the STEP parameter, modulo 2^ADDR_W. The new value appears on `fetch_addr` in the next cycle.
- R3: On a cycle with `fetch_adv`=1 and `br_taken`=1, the selected counter is loaded with `br_target` in either mode.
- R4: With `fetch_adv`=0, `fetch_addr` and `in_handler` keep their values in the next cycle. This holds even when `swap_dec` or `msg_valid` is high.
- R5: `msg_ready` equals `fetch_adv` AND NOT `in_handler`. A message is taken only in a cycle where `msg_valid` and `msg_ready` are both 1.
- R6: When a message is taken and `msg_pid` equals `cur_pid`, `in_handler` is 1 in the next cycle and `fetch_addr` equals that message's `msg_handler_addr`. The computation counter keeps the value it reached by that boundary's advance or branch.
- R7: When a message is taken and `msg_pid` differs from `cur_pid`, `kern_irq` is 1 for exactly the next cycle. In that case `in_handler` stays 0 and the computation counter advances as in R2/R3.
- R8: While `in_handler` is 1, `msg_ready` is 0, so arriving messages wait until after the swap back.
- R9: With `in_handler`=1, `fetch_adv`=1 and `swap_dec`=1, the next cycle has `in_handler`=0 and `fetch_addr` equal to the saved computation counter. Outside handler mode `swap_dec` has no effect.
- R10: The counter that is not selected does not change. The computation counter resumes exactly where it stopped once the handler returns.
- R11: A message that is waiting during a swap is taken on the first boundary after the swap. One computation instruction is fetched between the two handlers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Arrived message is present |
| msg_ready | output | 1 | Message is taken in this cycle if valid |
| msg_handler_addr | input | ADDR_W | Handler entry address from the message head |
| msg_pid | input | PID_W | Target process of the message |
| cur_pid | input | PID_W | Process now running |
| fetch_adv | input | 1 | Current fetch completes; instruction boundary |
| br_taken | input | 1 | Fetched instruction redirects to `br_target` |
| br_target | input | ADDR_W | Branch destination |
| swap_dec | input | 1 | Fetched instruction is a swap |
| fetch_addr | output | ADDR_W | Address of the instruction being fetched |
| in_handler | output | 1 | 1 when the handler counter is selected |
| kern_irq | output | 1 | One-cycle kernel interrupt request for a foreign message |

## Verification
The bench builds the block with ADDR_W=8, PID_W=2, STEP=4 and RESET_PC=8'hF0. With the reset address this close to the top of the range, the sequential wrap of R2 is reached in four fetches. The two-bit process id is enough to set a matching message against a foreign one. The narrow addresses keep the expected values easy to read in the back-to-back handler, swap-with-branch and foreign-trap sequences.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  typedef enum logic {
    SEL_COMP = 1'b0,
    SEL_HDL  = 1'b1
  } pc_sel_e;
endpackage

// File: rtl/fsw_pc_unit.sv
module fsw_pc_unit #(
  parameter int                ADDR_W = 16,
  parameter int                STEP   = 4,
  parameter logic [ADDR_W-1:0] RST_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] pc
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  always_ff @(posedge clk) begin
    if (!rst_n)        pc <= RST_PC;
    else if (load)     pc <= load_val;
    else if (adv)      pc <= br_taken ? br_target : pc + STEP_V;
  end
endmodule

// File: rtl/fsw_mode_ctrl.sv
module fsw_mode_ctrl
  import fsw_pkg::*;
#(
  parameter int PID_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_adv,
  input  logic             swap_dec,
  input  logic             msg_valid,
  input  logic [PID_W-1:0] msg_pid,
  input  logic [PID_W-1:0] cur_pid,
  output pc_sel_e          sel,
  output logic             msg_ready,
  output logic             take_hdl,
  output logic             kern_irq
);
  logic accept;
  logic trap;

  // Boundary-only acceptance, and never while a handler is running.
  assign msg_ready = fetch_adv && (sel == SEL_COMP);
  assign accept    = msg_valid && msg_ready;
  assign take_hdl  = accept && (msg_pid == cur_pid);
  assign trap      = accept && (msg_pid != cur_pid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel      <= SEL_COMP;
      kern_irq <= 1'b0;
    end else begin
      kern_irq <= trap;
      case (sel)
        SEL_COMP: if (take_hdl) sel <= SEL_HDL;
        SEL_HDL:  if (fetch_adv && swap_dec) sel <= SEL_COMP;
        default:  sel <= SEL_COMP;
      endcase
    end
  end
endmodule

// File: rtl/msg_fetch_switch.sv
module msg_fetch_switch
  import fsw_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                PID_W    = 4,
  parameter int                STEP     = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  output logic              msg_ready,
  input  logic [ADDR_W-1:0] msg_handler_addr,
  input  logic [PID_W-1:0]  msg_pid,
  input  logic [PID_W-1:0]  cur_pid,
  input  logic              fetch_adv,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              swap_dec,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              in_handler,
  output logic              kern_irq
);
  localparam int NUM_PC = 2;

  pc_sel_e           sel;
  logic              take_hdl;
  logic [ADDR_W-1:0] pc_q [NUM_PC];
  logic [ADDR_W-1:0] comp_pc;
  logic [ADDR_W-1:0] hdl_pc;

  fsw_mode_ctrl #(.PID_W(PID_W)) mode_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_adv (fetch_adv),
    .swap_dec  (swap_dec),
    .msg_valid (msg_valid),
    .msg_pid   (msg_pid),
    .cur_pid   (cur_pid),
    .sel       (sel),
    .msg_ready (msg_ready),
    .take_hdl  (take_hdl),
    .kern_irq  (kern_irq)
  );

  // Index 0: computation counter, index 1: handler counter.
  for (genvar i = 0; i < NUM_PC; i++) begin : g_pc
    localparam logic [ADDR_W-1:0] RST_I = (i == 0) ? RESET_PC : '0;
    logic active;
    logic load;
    assign active = (i == 0) ? (sel == SEL_COMP) : (sel == SEL_HDL);
    assign load   = (i == 1) && take_hdl;
    fsw_pc_unit #(.ADDR_W(ADDR_W), .STEP(STEP), .RST_PC(RST_I)) pc_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (fetch_adv && active),
      .br_taken  (br_taken),
      .br_target (br_target),
      .load      (load),
      .load_val  (msg_handler_addr),
      .pc        (pc_q[i])
    );
  end

  assign comp_pc    = pc_q[0];
  assign hdl_pc     = pc_q[1];
  assign in_handler = (sel == SEL_HDL);
  assign fetch_addr = in_handler ? hdl_pc : comp_pc;
endmodule

// File: rtl/fsw_chk.sv
module fsw_chk #(
  parameter int ADDR_W = 16,
  parameter int PID_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [ADDR_W-1:0] msg_handler_addr,
  input logic [PID_W-1:0]  msg_pid,
  input logic [PID_W-1:0]  cur_pid,
  input logic              fetch_adv,
  input logic              swap_dec,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              in_handler,
  input logic              kern_irq,
  input logic [ADDR_W-1:0] comp_pc,
  input logic [ADDR_W-1:0] hdl_pc
);
  assert_hold_no_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_adv |=> $stable(fetch_addr) && $stable(in_handler));

  assert_no_take_in_handler_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_handler |-> !msg_ready);

  assert_enter_handler_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready && msg_pid == cur_pid)
      |=> in_handler && fetch_addr == $past(msg_handler_addr));

  assert_trap_foreign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready && msg_pid != cur_pid) |=> kern_irq && !in_handler);

  assert_irq_only_on_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(msg_valid && msg_ready && msg_pid != cur_pid) |=> !kern_irq);

  assert_swap_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_handler && fetch_adv && swap_dec) |=> !in_handler && fetch_addr == $past(comp_pc));

  assert_comp_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_handler |=> $stable(comp_pc));

  assert_hdl_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_handler && !(msg_valid && msg_ready)) |=> $stable(hdl_pc));
endmodule

bind msg_fetch_switch fsw_chk #(.ADDR_W(ADDR_W), .PID_W(PID_W)) chk_i (
  .clk              (clk),
  .rst_n            (rst_n),
  .msg_valid        (msg_valid),
  .msg_ready        (msg_ready),
  .msg_handler_addr (msg_handler_addr),
  .msg_pid          (msg_pid),
  .cur_pid          (cur_pid),
  .fetch_adv        (fetch_adv),
  .swap_dec         (swap_dec),
  .fetch_addr       (fetch_addr),
  .in_handler       (in_handler),
  .kern_irq         (kern_irq),
  .comp_pc          (comp_pc),
  .hdl_pc           (hdl_pc)
);

// File: tb/msg_fetch_switch_tb_top.sv
module msg_fetch_switch_tb_top;
  localparam int          AW   = 8;
  localparam int          PW   = 2;
  localparam int          STP  = 4;
  localparam logic [7:0]  RPC  = 8'hF0;

  typedef struct {
    logic [AW-1:0] addr;
    logic          hdl;
    logic          irq;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          msg_valid = 1'b0;
  logic          msg_ready;
  logic [AW-1:0] msg_handler_addr = '0;
  logic [PW-1:0] msg_pid = '0;
  logic [PW-1:0] cur_pid = 2'd1;
  logic          fetch_adv = 1'b0;
  logic          br_taken = 1'b0;
  logic [AW-1:0] br_target = '0;
  logic          swap_dec = 1'b0;
  logic [AW-1:0] fetch_addr;
  logic          in_handler;
  logic          kern_irq;

  int checks = 0;
  int fails  = 0;
  exp_t sb_q[$];

  logic [AW-1:0] m_comp, m_hdl;
  logic          m_mode;

  always #10 clk = ~clk;

  msg_fetch_switch #(.ADDR_W(AW), .PID_W(PW), .STEP(STP), .RESET_PC(RPC)) dut_i (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_handler_addr(msg_handler_addr), .msg_pid(msg_pid), .cur_pid(cur_pid),
    .fetch_adv(fetch_adv), .br_taken(br_taken), .br_target(br_target),
    .swap_dec(swap_dec), .fetch_addr(fetch_addr), .in_handler(in_handler),
    .kern_irq(kern_irq)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus at the falling edge, check the
  // ready handshake, then push the post-edge expectation for the monitor.
  task automatic cyc(input string req, input logic adv, input logic br,
                     input logic [AW-1:0] tgt, input logic swp, input logic mv,
                     input logic [PW-1:0] pid, input logic [AW-1:0] ha);
    logic rdy, acc;
    exp_t e;
    fetch_adv = adv; br_taken = br; br_target = tgt; swap_dec = swp;
    msg_valid = mv; msg_pid = pid; msg_handler_addr = ha;
    #1;
    rdy = adv && !m_mode;
    chk(m_mode ? "R8 ready" : "R5 ready", AW'(msg_ready), AW'(rdy));
    acc = mv && rdy;
    e.irq = 1'b0;
    if (!m_mode) begin
      if (adv) m_comp = br ? tgt : m_comp + AW'(STP);
      if (acc && pid == cur_pid) begin m_hdl = ha; m_mode = 1'b1; end
      if (acc && pid != cur_pid) e.irq = 1'b1;
    end else begin
      if (adv) m_hdl = br ? tgt : m_hdl + AW'(STP);
      if (adv && swp) m_mode = 1'b0;
    end
    e.addr = m_mode ? m_hdl : m_comp;
    e.hdl  = m_mode;
    e.req  = req;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: compare outputs a quarter period after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.req, " addr"}, fetch_addr, e.addr);
        chk({e.req, " mode"}, AW'(in_handler), AW'(e.hdl));
        chk({e.req, " irq"},  AW'(kern_irq), AW'(e.irq));
      end
    end
  end

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_comp = RPC; m_hdl = '0; m_mode = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 addr", fetch_addr, RPC);
    chk("R1 mode", AW'(in_handler), '0);
    chk("R1 irq",  AW'(kern_irq), '0);
    rst_n = 1'b1;
    @(negedge clk);
    cyc("R2 seq",  1, 0, 8'h00, 0, 0, 0, 8'h00);
    cyc("R2 seq",  1, 0, 8'h00, 0, 0, 0, 8'h00);
    cyc("R2 seq",  1, 0, 8'h00, 0, 0, 0, 8'h00);
    cyc("R2 wrap", 1, 0, 8'h00, 0, 0, 0, 8'h00);
    cyc("R4 hold", 0, 0, 8'h00, 1, 0, 0, 8'h00);
    cyc("R3 comp branch", 1, 1, 8'h40, 0, 0, 0, 8'h00);
    cyc("R5 no boundary", 0, 0, 8'h00, 0, 1, 2'd1, 8'hA0);
    cyc("R6 enter", 1, 0, 8'h00, 0, 1, 2'd1, 8'hA0);
    cyc("R8 pending", 1, 0, 8'h00, 0, 1, 2'd1, 8'hC0);
    cyc("R3 hdl branch", 1, 1, 8'hB0, 0, 1, 2'd1, 8'hC0);
    cyc("R4 swap no adv", 0, 0, 8'h00, 1, 1, 2'd1, 8'hC0);
    cyc("R9 swap", 1, 0, 8'h00, 1, 1, 2'd1, 8'hC0);
    cyc("R11 next handler", 1, 0, 8'h00, 0, 1, 2'd1, 8'hC0);
    cyc("R10 hdl run", 1, 0, 8'h00, 0, 0, 0, 8'h00);
    cyc("R10 resume", 1, 0, 8'h00, 1, 0, 0, 8'h00);
    cyc("R7 foreign", 1, 0, 8'h00, 0, 1, 2'd2, 8'h80);
    cyc("R7 irq drop", 1, 0, 8'h00, 0, 0, 0, 8'h00);
    cyc("R6 enter with branch", 1, 1, 8'h20, 0, 1, 2'd1, 8'h90);
    cyc("R9 swap back", 1, 0, 8'h00, 1, 0, 0, 8'h00);
    cyc("R9 swap ignored", 1, 0, 8'h00, 1, 0, 0, 8'h00);
    cyc("R2 idle", 0, 0, 8'h00, 0, 0, 0, 8'h00);
    @(posedge clk);
    #6;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule